// File: doc/BRIEF.md
# Processor Store Queue with Read Latch

This block sits between a processor bus and a memory controller. Stores from the processor go into a small in-order queue, so the processor keeps running instead of waiting on memory. The queue retires its entries to the memory controller one at a time through a valid/ready handshake. Entries are never combined or reordered.

Each write offered to memory carries a page-hit flag. A write whose page matches the page of the write retired just before it is offered on the next clock. This lets the controller stay in page mode and retire one write per cycle. A write to a different page waits one idle cycle first. A page is the address above bit `PAGE_LSB`, which gives 4 KiB pages by default.

Reads take a separate path. The read address is latched, held back until every queued store has retired, and then passed to memory. The returned word is captured in a single-entry read latch together with per-byte parity and handed to the processor. Read-after-write conflicts with queued stores are left to the memory controller.

Top module: `wbuf_top`

## Requirements
- R1: After reset, `cpu_st_full`, `mem_wr_valid`, `mem_rd_valid`, `cpu_rd_valid` and `cpu_rd_busy` are all low.
- R2: A store is accepted at the clock edge where it is presented, provided fewer than `DEPTH` stores are pending. `cpu_st_full` is high exactly when `DEPTH` stores are pending.
- R3: A store presented while `cpu_st_full` is high is accepted only if a queued write retires in the same cycle. Otherwise it is ignored and never reaches memory.
- R4: Writes reach memory in the order their stores were accepted, each exactly once. Stores to the same address are not merged.
- R5: While `mem_wr_valid` is high and `mem_wr_ready` is low, the offered address and data stay unchanged and `mem_wr_valid` stays high.
- R6: When the next queued write is in the same page as the write just retired, it is offered on the following cycle. With `mem_wr_ready` held high, a same-page run retires one write per clock.
- R7: A write whose page differs from the last retired write's page is offered only after one idle cycle. The same applies to any write when nothing has retired since reset.
- R8: `mem_wr_page_hit` is high with an offered write exactly when its page equals the page of the previously retired write.
- R9: A read request is forwarded on `mem_rd_valid`, carrying the requested address, only when no store is pending. Stores still queued hold it back.
- R10: The cycle after `mem_rd_resp_valid`, `cpu_rd_valid` pulses high for one cycle with the returned word on `cpu_rd_data`. The latch keeps that word until the next capture. `cpu_rd_busy` is high from the cycle after a request until that pulse, and requests are taken only while it is low.
- R11: `cpu_rd_par[i]` is the even-parity bit of `cpu_rd_data[8i+7:8i]`, which is the XOR of that byte. Each byte plus its bit therefore holds an even number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_st_valid | input | 1 | Store request |
| cpu_st_addr | input | AW | Store address |
| cpu_st_data | input | DW | Store data |
| cpu_st_full | output | 1 | Queue holds DEPTH stores |
| cpu_rd_req | input | 1 | Read request, taken when busy is low |
| cpu_rd_addr | input | AW | Read address |
| cpu_rd_busy | output | 1 | Read in progress |
| cpu_rd_valid | output | 1 | One-cycle pulse: read data ready |
| cpu_rd_data | output | DW | Read latch data |
| cpu_rd_par | output | DW/8 | Per-byte even parity of the latch |
| mem_wr_valid | output | 1 | Write offered to memory |
| mem_wr_ready | input | 1 | Memory takes the offered write |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Write data |
| mem_wr_page_hit | output | 1 | Offered write is in the last retired write's page |
| mem_rd_valid | output | 1 | Read address offered to memory |
| mem_rd_ready | input | 1 | Memory takes the read address |
| mem_rd_addr | output | AW | Read address to memory |
| mem_rd_resp_valid | input | 1 | Read data returned |
| mem_rd_resp_data | input | DW | Returned read data |

## Verification
The bench builds the block with `DEPTH=4` and `PAGE_LSB=4`. Small addresses therefore cross 16-byte pages, and four stores fill the queue. This makes it practical to sweep all 16 same-page/new-page patterns for a full batch of four writes and to predict each retirement cycle and page-hit flag by simple arithmetic. It also puts full-queue behaviour (ignored and same-cycle-retire stores), drain-before-read ordering, and a sweep of single-bit and mixed read words for per-byte parity within a short run.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_DRAIN = 2'd1,
    RD_RESP  = 2'd2
  } rd_state_e;

  // even parity bit of one byte: the XOR of its bits
  function automatic logic byte_even_par(input logic [7:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/wbuf_fifo.sv
`timescale 1ns/1ps
module wbuf_fifo #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [AW-1:0]              head_addr,
  output logic [DW-1:0]              head_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  // ring pointer step, wraps at DEPTH-1 (DEPTH need not be a power of two)
  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr_q] <= push_addr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      unique case ({push, pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_addr = addr_q[rd_ptr_q];
  assign head_data = data_q[rd_ptr_q];
  assign count     = count_q;
  assign empty     = (count_q == '0);
  assign full      = (count_q == CW'(DEPTH));
endmodule

// File: rtl/wbuf_issue.sv
`timescale 1ns/1ps
module wbuf_issue #(
  parameter int AW       = 32,
  parameter int PAGE_LSB = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          empty,
  input  logic [AW-1:0] head_addr,
  input  logic          mem_wr_ready,
  output logic          issue,
  output logic          head_hit,
  output logic          pop
);
  localparam int PGW = AW - PAGE_LSB;

  logic [PGW-1:0] last_page_q;
  logic           last_ok_q;
  logic           wait_q;

  function automatic logic [PGW-1:0] page_of(input logic [AW-1:0] a);
    return a[AW-1:PAGE_LSB];
  endfunction

  assign head_hit = last_ok_q && (page_of(head_addr) == last_page_q);
  assign issue    = !empty && (head_hit || wait_q);
  assign pop      = issue && mem_wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_page_q <= '0;
      last_ok_q   <= 1'b0;
      wait_q      <= 1'b0;
    end else if (pop) begin
      last_page_q <= page_of(head_addr);
      last_ok_q   <= 1'b1;
      wait_q      <= 1'b0;
    end else if (!empty && !head_hit) begin
      wait_q      <= 1'b1;   // one idle cycle paid for a page change
    end
  end
endmodule

// File: rtl/wbuf_rdlatch.sv
`timescale 1ns/1ps
module wbuf_rdlatch #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_rd_req,
  input  logic [AW-1:0]   cpu_rd_addr,
  input  logic            wq_empty,
  input  logic            mem_rd_ready,
  input  logic            mem_rd_resp_valid,
  input  logic [DW-1:0]   mem_rd_resp_data,
  output logic            cpu_rd_busy,
  output logic            mem_rd_valid,
  output logic [AW-1:0]   mem_rd_addr,
  output logic            cpu_rd_valid,
  output logic [DW-1:0]   cpu_rd_data,
  output logic [DW/8-1:0] cpu_rd_par,
  output logic            rd_capture
);
  import wbuf_pkg::*;
  localparam int NB = DW / 8;

  rd_state_e       state_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  logic [NB-1:0]   par_q, par_next;
  logic            vld_q;

  for (genvar g = 0; g < NB; g++) begin : g_par
    assign par_next[g] = byte_even_par(mem_rd_resp_data[8*g +: 8]);
  end

  assign mem_rd_valid = (state_q == RD_DRAIN) && wq_empty;
  assign rd_capture   = (state_q == RD_RESP) && mem_rd_resp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      par_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (state_q)
        RD_IDLE: if (cpu_rd_req) begin
          addr_q  <= cpu_rd_addr;
          state_q <= RD_DRAIN;
        end
        RD_DRAIN: if (mem_rd_valid && mem_rd_ready) state_q <= RD_RESP;
        RD_RESP: if (rd_capture) begin
          data_q  <= mem_rd_resp_data;
          par_q   <= par_next;
          vld_q   <= 1'b1;
          state_q <= RD_IDLE;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign cpu_rd_busy  = (state_q != RD_IDLE);
  assign mem_rd_addr  = addr_q;
  assign cpu_rd_valid = vld_q;
  assign cpu_rd_data  = data_q;
  assign cpu_rd_par   = par_q;
endmodule

// File: rtl/wbuf_top.sv
`timescale 1ns/1ps
module wbuf_top #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int DEPTH    = 6,
  parameter int PAGE_LSB = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_st_valid,
  input  logic [AW-1:0]   cpu_st_addr,
  input  logic [DW-1:0]   cpu_st_data,
  output logic            cpu_st_full,
  input  logic            cpu_rd_req,
  input  logic [AW-1:0]   cpu_rd_addr,
  output logic            cpu_rd_busy,
  output logic            cpu_rd_valid,
  output logic [DW-1:0]   cpu_rd_data,
  output logic [DW/8-1:0] cpu_rd_par,
  output logic            mem_wr_valid,
  input  logic            mem_wr_ready,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [DW-1:0]   mem_wr_data,
  output logic            mem_wr_page_hit,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [AW-1:0]   mem_rd_addr,
  input  logic            mem_rd_resp_valid,
  input  logic [DW-1:0]   mem_rd_resp_data
);
  localparam int CW = $clog2(DEPTH + 1);

  // named internal events, observed by the bound checker
  logic          wq_push, wq_pop, wq_empty, wq_full, head_hit, rd_capture;
  logic [CW-1:0] wq_count;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;

  assign wq_push = cpu_st_valid && (!wq_full || wq_pop);

  wbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wq_push),
    .push_addr (cpu_st_addr),
    .push_data (cpu_st_data),
    .pop       (wq_pop),
    .head_addr (head_addr),
    .head_data (head_data),
    .count     (wq_count),
    .empty     (wq_empty),
    .full      (wq_full)
  );

  wbuf_issue #(.AW(AW), .PAGE_LSB(PAGE_LSB)) u_issue (
    .clk          (clk),
    .rst_n        (rst_n),
    .empty        (wq_empty),
    .head_addr    (head_addr),
    .mem_wr_ready (mem_wr_ready),
    .issue        (mem_wr_valid),
    .head_hit     (head_hit),
    .pop          (wq_pop)
  );

  wbuf_rdlatch #(.AW(AW), .DW(DW)) u_rd (
    .clk               (clk),
    .rst_n             (rst_n),
    .cpu_rd_req        (cpu_rd_req),
    .cpu_rd_addr       (cpu_rd_addr),
    .wq_empty          (wq_empty),
    .mem_rd_ready      (mem_rd_ready),
    .mem_rd_resp_valid (mem_rd_resp_valid),
    .mem_rd_resp_data  (mem_rd_resp_data),
    .cpu_rd_busy       (cpu_rd_busy),
    .mem_rd_valid      (mem_rd_valid),
    .mem_rd_addr       (mem_rd_addr),
    .cpu_rd_valid      (cpu_rd_valid),
    .cpu_rd_data       (cpu_rd_data),
    .cpu_rd_par        (cpu_rd_par),
    .rd_capture        (rd_capture)
  );

  assign cpu_st_full     = wq_full;
  assign mem_wr_addr     = head_addr;
  assign mem_wr_data     = head_data;
  assign mem_wr_page_hit = head_hit;
endmodule

// File: rtl/wbuf_checks.sv
`timescale 1ns/1ps
module wbuf_checks #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cpu_st_valid,
  input logic                       cpu_st_full,
  input logic                       wq_push,
  input logic                       wq_pop,
  input logic [$clog2(DEPTH+1)-1:0] wq_count,
  input logic                       head_hit,
  input logic                       mem_wr_valid,
  input logic                       mem_wr_ready,
  input logic [AW-1:0]              mem_wr_addr,
  input logic [DW-1:0]              mem_wr_data,
  input logic                       mem_wr_page_hit,
  input logic                       mem_rd_valid,
  input logic                       cpu_rd_valid,
  input logic [DW-1:0]              cpu_rd_data,
  input logic [DW/8-1:0]            cpu_rd_par
);
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wq_count <= ($clog2(DEPTH+1))'(DEPTH));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_st_full && cpu_st_valid && !wq_pop) |-> !wq_push);

  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wq_pop |=> (wq_count == '0 || !head_hit || mem_wr_valid));

  assert_miss_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_wr_valid) && !mem_wr_page_hit) |-> $past(wq_count != '0));

  assert_read_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (!mem_wr_valid && wq_count == '0));

  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_valid |=> !cpu_rd_valid);

  for (genvar g = 0; g < DW/8; g++) begin : g_par_chk
    assert_rd_parity_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd_valid |-> ($countones({cpu_rd_data[8*g +: 8], cpu_rd_par[g]}) % 2 == 0));
  end
endmodule

bind wbuf_top wbuf_checks #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_checks (
  .clk             (clk),
  .rst_n           (rst_n),
  .cpu_st_valid    (cpu_st_valid),
  .cpu_st_full     (cpu_st_full),
  .wq_push         (wq_push),
  .wq_pop          (wq_pop),
  .wq_count        (wq_count),
  .head_hit        (head_hit),
  .mem_wr_valid    (mem_wr_valid),
  .mem_wr_ready    (mem_wr_ready),
  .mem_wr_addr     (mem_wr_addr),
  .mem_wr_data     (mem_wr_data),
  .mem_wr_page_hit (mem_wr_page_hit),
  .mem_rd_valid    (mem_rd_valid),
  .cpu_rd_valid    (cpu_rd_valid),
  .cpu_rd_data     (cpu_rd_data),
  .cpu_rd_par      (cpu_rd_par)
);

// File: tb/wbuf_top_bench.sv
`timescale 1ns/1ps
module wbuf_top_bench;
  localparam int AW = 32, DW = 32, DEPTH = 4, PAGE_LSB = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cpu_st_valid = 1'b0;
  logic [AW-1:0] cpu_st_addr = '0;
  logic [DW-1:0] cpu_st_data = '0;
  logic          cpu_st_full;
  logic          cpu_rd_req = 1'b0;
  logic [AW-1:0] cpu_rd_addr = '0;
  logic          cpu_rd_busy, cpu_rd_valid;
  logic [DW-1:0] cpu_rd_data;
  logic [3:0]    cpu_rd_par;
  logic          mem_wr_valid, mem_wr_page_hit;
  logic          mem_wr_ready = 1'b0;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          mem_rd_valid;
  logic          mem_rd_ready = 1'b1;
  logic [AW-1:0] mem_rd_addr;
  logic          mem_rd_resp_valid = 1'b0;
  logic [DW-1:0] mem_rd_resp_data = '0;

  wbuf_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .PAGE_LSB(PAGE_LSB)) u_wbuf_top (.*);

  int checks = 0, errors = 0, cyc = 0, wn = 0;
  logic [AW-1:0] lg_addr [512];
  logic [DW-1:0] lg_data [512];
  logic          lg_hit  [512];
  int            lg_cyc  [512];

  // write-side memory monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_wr_valid && mem_wr_ready && wn < 512) begin
      lg_addr[wn] <= mem_wr_addr;
      lg_data[wn] <= mem_wr_data;
      lg_hit[wn]  <= mem_wr_page_hit;
      lg_cyc[wn]  <= cyc;
      wn <= wn + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 20000) begin
    errors++;
    $display("FAIL watchdog (all requirements) actual=%0d expected=<20000", cyc);
    summary();
  end

  function automatic logic [AW-1:0] mk_addr(input int page, input int off);
    return AW'(page * (1 << PAGE_LSB) + off);
  endfunction

  function automatic logic [3:0] exp_par(input logic [DW-1:0] d);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) p[b] = ($countones(d[8*b +: 8]) % 2) == 1;
    return p;
  endfunction

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cpu_st_valid = 1'b1; cpu_st_addr = a; cpu_st_data = d;
    @(negedge clk);
    cpu_st_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    logic [DW-1:0] held;
    cpu_rd_req = 1'b1; cpu_rd_addr = ra;
    @(negedge clk);
    cpu_rd_req = 1'b0;
    for (int k = 0; k < 40 && !mem_rd_valid; k++) @(negedge clk);
    chk(mem_rd_valid && mem_rd_addr == ra, "R9 read address forwarded", mem_rd_addr, ra);
    @(negedge clk);
    chk(cpu_rd_busy, "R10 busy while waiting", cpu_rd_busy, 1);
    mem_rd_resp_valid = 1'b1; mem_rd_resp_data = rd;
    @(negedge clk);
    mem_rd_resp_valid = 1'b0; mem_rd_resp_data = ~rd;
    chk(cpu_rd_valid && cpu_rd_data == rd, "R10 read data pulse", {cpu_rd_valid, cpu_rd_data}, {1'b1, rd});
    chk(cpu_rd_par == exp_par(rd), "R11 read parity", cpu_rd_par, exp_par(rd));
    held = cpu_rd_data;
    @(negedge clk);
    chk(!cpu_rd_valid && !cpu_rd_busy && cpu_rd_data == held, "R10 pulse ends, data held",
        {cpu_rd_valid, cpu_rd_busy, cpu_rd_data}, {2'b00, rd});
  endtask

  initial begin
    int pg, last_pg, n0, pgs[4];
    logic [DW-1:0] rv;
    pg = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!cpu_st_full && !mem_wr_valid && !mem_rd_valid && !cpu_rd_valid && !cpu_rd_busy,
        "R1 reset outputs", {cpu_st_full, mem_wr_valid, mem_rd_valid, cpu_rd_valid, cpu_rd_busy}, 0);

    // A: fill, ignored store while full, order, no merge, hold
    mem_wr_ready = 1'b0;
    pg++;
    for (int j = 0; j < DEPTH; j++) begin
      chk(!cpu_st_full, "R2 not full before DEPTH", cpu_st_full, 0);
      store(mk_addr(pg, (j == 2) ? 4 : j * 4), 32'hA000 + j);
    end
    chk(cpu_st_full, "R2 full at DEPTH", cpu_st_full, 1);
    store(mk_addr(pg, 8), 32'hBAD0BAD0);
    repeat (3) @(negedge clk);
    chk(mem_wr_valid && mem_wr_addr == mk_addr(pg, 0) && mem_wr_data == 32'hA000,
        "R5 write held while not ready", mem_wr_addr, mk_addr(pg, 0));
    n0 = wn;
    mem_wr_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk(wn - n0 == DEPTH, "R3 ignored store absent", wn - n0, DEPTH);
    for (int j = 0; j < DEPTH; j++)
      chk(lg_addr[n0+j] == mk_addr(pg, (j == 2) ? 4 : j * 4) && lg_data[n0+j] == 32'hA000 + j,
          "R4 order, no merge", lg_data[n0+j], 32'hA000 + j);
    last_pg = pg;

    // B: store while full in the retire cycle
    mem_wr_ready = 1'b0;
    pg++;
    for (int j = 0; j < DEPTH; j++) store(mk_addr(pg, j * 4), 32'hB000 + j);
    repeat (3) @(negedge clk);
    chk(cpu_st_full && mem_wr_valid, "R3 full with head offered", {cpu_st_full, mem_wr_valid}, 3);
    n0 = wn;
    mem_wr_ready = 1'b1;
    store(mk_addr(pg, 12), 32'hB0FF);
    repeat (10) @(negedge clk);
    chk(wn - n0 == DEPTH + 1, "R3 store accepted on retire", wn - n0, DEPTH + 1);
    chk(lg_data[n0+DEPTH] == 32'hB0FF, "R3 accepted store last", lg_data[n0+DEPTH], 32'hB0FF);
    last_pg = pg;

    // C: all 16 hit/miss patterns over a full batch
    for (int m = 0; m < 16; m++) begin
      mem_wr_ready = 1'b0;
      for (int j = 0; j < 4; j++) begin
        if (m[j]) pgs[j] = (j == 0) ? last_pg : pgs[j-1];
        else begin pg++; pgs[j] = pg; end
        store(mk_addr(pgs[j], j * 4), 32'hC000 + m * 16 + j);
      end
      repeat (3) @(negedge clk);
      n0 = wn;
      mem_wr_ready = 1'b1;
      repeat (10) @(negedge clk);
      chk(wn - n0 == 4, "R6 batch drained", wn - n0, 4);
      for (int j = 0; j < 4; j++) begin
        chk(lg_hit[n0+j] == m[j], "R8 page hit flag", lg_hit[n0+j], m[j]);
        chk(lg_data[n0+j] == 32'hC000 + m * 16 + j, "R4 batch order", lg_data[n0+j], 32'hC000 + m * 16 + j);
        if (j > 0)
          chk(lg_cyc[n0+j] - lg_cyc[n0+j-1] == (m[j] ? 1 : 2),
              m[j] ? "R6 same page next cycle" : "R7 new page idle cycle",
              lg_cyc[n0+j] - lg_cyc[n0+j-1], m[j] ? 1 : 2);
      end
      last_pg = pgs[3];
    end

    // D: read held back by queued stores
    mem_wr_ready = 1'b0;
    pg++; store(mk_addr(pg, 0), 32'hD000);
    pg++; store(mk_addr(pg, 0), 32'hD001);
    cpu_rd_req = 1'b1; cpu_rd_addr = 32'h0000_5550;
    @(negedge clk);
    cpu_rd_req = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(!mem_rd_valid && cpu_rd_busy, "R9 read blocked by pending stores", mem_rd_valid, 0);
      @(negedge clk);
    end
    n0 = wn;
    mem_wr_ready = 1'b1;
    for (int k = 0; k < 20 && !mem_rd_valid; k++) @(negedge clk);
    chk(mem_rd_valid && wn - n0 == 2 && mem_rd_addr == 32'h0000_5550,
        "R9 read after drain", {mem_rd_valid, 8'(wn - n0)}, {1'b1, 8'd2});
    @(negedge clk);
    mem_rd_resp_valid = 1'b1; mem_rd_resp_data = 32'h8001_7F00;
    @(negedge clk);
    mem_rd_resp_valid = 1'b0;
    chk(cpu_rd_valid && cpu_rd_data == 32'h8001_7F00, "R10 capture after drain", cpu_rd_data, 32'h8001_7F00);

    // E: read sweep for data and parity
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      if (i < 32) rv = 32'h1 << i;
      else if (i == 32) rv = '0;
      else if (i == 33) rv = '1;
      else rv = 32'(i) * 32'h9E37_79B9;
      do_read(32'h100 + 32'(i * 4), rv);
    end

    summary();
  end
endmodule